// File: doc/BRIEF.md
# Mixed-Length Instruction Parcel Sequencer

This block sits between an instruction word buffer and the issue logic of a processor whose 60-bit instruction words each carry four 15-bit parcels. An instruction is either one parcel long (short) or two parcels long (long). In every cycle the sequencer shows the issue logic a 30-bit window made of two adjacent parcels, so that a long instruction is always seen whole. A predecode of the leading parcel in the window tells the sequencer the instruction's length.

A short instruction uses up one parcel, and the window then moves on by one parcel. A long instruction uses up two parcels. The cycle after a long instruction is spent skipping its second half, and the window is marked invalid during that cycle. The pointer therefore moves by exactly one parcel per cycle that is not stalled, and each word takes at least four cycles. When the last parcel has been used, the block raises a one-cycle done pulse so the buffer can move up or fetch the next word.

A stall freezes the sequencer. A flush, raised on a branch, starts again at parcel 0 of the newly selected word.

Top module: `parcel_sequencer`

## Requirements
- R1: After reset the parcel pointer is 0. With a valid word present, the window shows parcels 0 and 1, and no skip is pending.
- R2: Parcel k of the word is bits [59-15k : 45-15k], so parcel 0 is the most significant. The window carries the parcel at the pointer in bits [29:15] and the next parcel in bits [14:0].
- R3: When a short instruction is shown (window valid, length input low) and no stall is present, the next cycle's window starts one parcel later.
- R4: When a long instruction is shown at parcel 0, 1 or 2 and no stall is present, the window is invalid in the next cycle (skip). In the cycle after that, the window starts two parcels past the long instruction.
- R5: With no stall, no flush and the word valid, the done pulse is high only in the cycle in which the pointer is at parcel 3. This includes a skip cycle at parcel 3. Each word therefore takes exactly four cycles, and the next cycle shows parcel 0.
- R6: When the pointer is at parcel 3, the lower window slot is all zeros.
- R7: A long indication while the window is valid at parcel 3 raises the length-error output in that cycle. The instruction is then treated as short: no skip follows, and the next cycle shows parcel 0 of the next word as valid.
- R8: While the stall input is high, the pointer and any pending skip hold. The window is unchanged and the done pulse stays low.
- R9: When flush is high, the window is invalid and the done pulse is low in that cycle. The next cycle shows parcels 0 and 1 with no pending skip.
- R10: While the word-valid input is low, the window is invalid, the done pulse is low and the pointer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordIn | input | 60 | Currently selected instruction word |
| wordValid | input | 1 | wordIn holds a valid word |
| isLong | input | 1 | Predecode: the leading window parcel starts a long instruction |
| stall | input | 1 | Issue logic cannot accept an instruction this cycle |
| flush | input | 1 | Branch taken: restart at parcel 0 of the new word |
| window | output | 30 | Two adjacent parcels, leading one in the upper half |
| windowValid | output | 1 | window holds an instruction to issue |
| wordDone | output | 1 | Last parcel of the word consumed this cycle |
| lenError | output | 1 | Long instruction shown in the final parcel |

## Verification
The window, windowValid, wordDone and lenError depend combinationally on the inputs and on the registered pointer and skip flag. Any input change is therefore seen in the same cycle, and the effect on the pointer or the skip state is seen one edge later. The bench changes inputs on the falling edge and checks the outputs one time unit later, well before the next rising edge. Each check compares the outputs with the values expected for that cycle's pointer position, and the bench works out that position itself from the sequence of lengths, stalls and flushes it has applied. The case that takes longest to show is the long instruction: the skip appears one cycle after the long instruction is shown, and the window moves on two cycles after it.

// File: rtl/parcel_seq_pkg.sv
package parcel_seq_pkg;
  // Strobes from the sequencing control to the parcel datapath
  typedef struct packed {
    logic advance;   // step the parcel pointer by one
    logic restart;   // force the parcel pointer to zero
  } seqStrobe_t;
endpackage

// File: rtl/parcel_seq_dp.sv
module parcel_seq_dp
  import parcel_seq_pkg::*;
#(
  parameter int PARCEL_W = 15,
  parameter int PARCELS  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [PARCEL_W*PARCELS-1:0] wordIn,
  input  seqStrobe_t                strobe,
  output logic [2*PARCEL_W-1:0]     window,
  output logic                      atLast
);
  localparam int WORD_W = PARCEL_W * PARCELS;
  localparam int PTR_W  = (PARCELS > 1) ? $clog2(PARCELS) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(PARCELS - 1);

  logic [PTR_W-1:0]    ptr;
  logic [PARCEL_W-1:0] slots [PARCELS+1];
  logic [PTR_W:0]      nextIdx;

  // Slice the word, leftmost parcel first; one trailing zero slot pads the window
  for (genvar i = 0; i < PARCELS; i++) begin : g_slice
    assign slots[i] = wordIn[WORD_W-1-i*PARCEL_W -: PARCEL_W];
  end
  assign slots[PARCELS] = '0;

  assign nextIdx = {1'b0, ptr} + (PTR_W+1)'(1);
  assign window  = {slots[ptr], slots[nextIdx]};
  assign atLast  = (ptr == LAST_PTR);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      ptr <= '0;
    end else if (strobe.advance) begin
      ptr <= atLast ? '0 : ptr + PTR_W'(1);
    end
  end

  // R8
  hold_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.restart) |=> $stable(ptr));

  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (ptr == '0));

  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    atLast |-> (window[PARCEL_W-1:0] == '0));
endmodule

// File: rtl/parcel_seq_ctrl.sv
module parcel_seq_ctrl
  import parcel_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordValid,
  input  logic       isLong,
  input  logic       stall,
  input  logic       flush,
  input  logic       atLast,
  output seqStrobe_t strobe,
  output logic       windowValid,
  output logic       wordDone,
  output logic       lenError
);
  logic skipPend;
  logic issueNow;
  logic stepNow;

  assign windowValid = wordValid && !skipPend && !flush;
  assign issueNow    = windowValid && !stall;
  assign stepNow     = wordValid && !stall && !flush;
  assign wordDone    = stepNow && atLast;
  assign lenError    = windowValid && isLong && atLast;

  assign strobe.advance = stepNow;
  assign strobe.restart = flush;

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      skipPend <= 1'b0;
    end else if (stepNow) begin
      // A long instruction not in the last slot skips its second half next cycle
      skipPend <= issueNow && isLong && !atLast;
    end
  end

  // R4
  long_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (windowValid && isLong && !atLast && !stall) |=> !windowValid);

  // R5
  done_at_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |-> atLast);

  // R10
  no_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> (!windowValid && !wordDone));

  // R7
  last_long_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lenError && !stall && wordValid) |=> (windowValid || !wordValid || flush));
endmodule

// File: rtl/parcel_sequencer.sv
module parcel_sequencer
  import parcel_seq_pkg::*;
#(
  parameter int PARCEL_W = 15,
  parameter int PARCELS  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PARCEL_W*PARCELS-1:0]   wordIn,
  input  logic                          wordValid,
  input  logic                          isLong,
  input  logic                          stall,
  input  logic                          flush,
  output logic [2*PARCEL_W-1:0]         window,
  output logic                          windowValid,
  output logic                          wordDone,
  output logic                          lenError
);
  seqStrobe_t strobe;
  logic       atLast;

  parcel_seq_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wordValid   (wordValid),
    .isLong      (isLong),
    .stall       (stall),
    .flush       (flush),
    .atLast      (atLast),
    .strobe      (strobe),
    .windowValid (windowValid),
    .wordDone    (wordDone),
    .lenError    (lenError)
  );

  parcel_seq_dp #(
    .PARCEL_W (PARCEL_W),
    .PARCELS  (PARCELS)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wordIn (wordIn),
    .strobe (strobe),
    .window (window),
    .atLast (atLast)
  );
endmodule

// File: tb/test_parcel_sequencer.sv
module test_parcel_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [59:0] wordIn = '0;
  logic        wordValid = 1'b0;
  logic        isLong = 1'b0;
  logic        stall = 1'b0;
  logic        flush = 1'b0;
  logic [29:0] window;
  logic        windowValid;
  logic        wordDone;
  logic        lenError;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parcel_sequencer i_parcel_sequencer (
    .clk (clk), .rstN (rstN), .wordIn (wordIn), .wordValid (wordValid),
    .isLong (isLong), .stall (stall), .flush (flush), .window (window),
    .windowValid (windowValid), .wordDone (wordDone), .lenError (lenError)
  );

  function automatic logic [14:0] par(input logic [59:0] w, input int k);
    return (k > 3) ? 15'h0 : w[59-15*k -: 15];
  endfunction

  function automatic logic [29:0] expWin(input logic [59:0] w, input int k);
    return {par(w, k), par(w, k+1)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle's inputs on the falling edge, then check the outputs of that cycle
  task automatic cyc(input logic wv, input logic lng, input logic st, input logic fl,
                     input logic eValid, input logic [29:0] eWin, input logic eDone,
                     input logic eErr, input string req);
    @(negedge clk);
    wordValid = wv; isLong = lng; stall = st; flush = fl;
    #1;
    chk({req, " valid"}, 64'(windowValid), 64'(eValid));
    if (eValid) chk({req, " window"}, 64'(window), 64'(eWin));
    chk({req, " done"}, 64'(wordDone), 64'(eDone));
    chk({req, " lenErr"}, 64'(lenError), 64'(eErr));
  endtask

  task automatic doFlush(input logic [59:0] w);
    @(negedge clk);
    wordIn = w;
    cyc(1, 0, 0, 1, 0, '0, 0, 0, "R9 flush cycle");
  endtask

  task automatic testReset();
    wordIn = 60'h123_4567_89AB_CDEF;
    cyc(1, 0, 1, 0, 1, expWin(wordIn, 0), 0, 0, "R1 reset window");
  endtask

  task automatic testAllShort();
    logic [59:0] w = 60'h0A1_B2C3_D4E5_F607;
    doFlush(w);
    cyc(1, 0, 0, 0, 1, expWin(w, 0), 0, 0, "R2 R3 short p0");
    cyc(1, 0, 0, 0, 1, expWin(w, 1), 0, 0, "R3 short p1");
    cyc(1, 0, 0, 0, 1, expWin(w, 2), 0, 0, "R3 short p2");
    cyc(1, 0, 0, 0, 1, expWin(w, 3), 1, 0, "R5 R6 short p3");
    chk("R6 pad", 64'(window[14:0]), 64'h0);
    wordIn = 60'hFED_CBA9_8765_4321;
    cyc(1, 0, 0, 0, 1, expWin(wordIn, 0), 0, 0, "R5 next word p0");
  endtask

  task automatic testLongFirst();
    logic [59:0] w = 60'h111_2222_3333_4444;
    doFlush(w);
    cyc(1, 1, 0, 0, 1, expWin(w, 0), 0, 0, "R4 long p0");
    cyc(1, 0, 0, 0, 0, '0, 0, 0, "R4 skip p1");
    cyc(1, 0, 0, 0, 1, expWin(w, 2), 0, 0, "R4 resume p2");
    cyc(1, 0, 0, 0, 1, expWin(w, 3), 1, 0, "R5 p3 after long");
  endtask

  task automatic testLongThird();
    logic [59:0] w = 60'h5A5_A5A5_1234_7F7F;
    doFlush(w);
    cyc(1, 0, 0, 0, 1, expWin(w, 0), 0, 0, "R3 p0");
    cyc(1, 0, 0, 0, 1, expWin(w, 1), 0, 0, "R3 p1");
    cyc(1, 1, 0, 0, 1, expWin(w, 2), 0, 0, "R4 long p2");
    cyc(1, 0, 0, 0, 0, '0, 1, 0, "R5 skip at p3 done");
    cyc(1, 0, 0, 0, 1, expWin(w, 0), 0, 0, "R5 wrap p0");
  endtask

  task automatic testLongLast();
    logic [59:0] w = 60'h3C3_C3C3_0F0F_F0F0;
    doFlush(w);
    cyc(1, 0, 0, 0, 1, expWin(w, 0), 0, 0, "R3 p0");
    cyc(1, 0, 0, 0, 1, expWin(w, 1), 0, 0, "R3 p1");
    cyc(1, 0, 0, 0, 1, expWin(w, 2), 0, 0, "R3 p2");
    cyc(1, 1, 0, 0, 1, expWin(w, 3), 1, 1, "R7 long at p3");
    cyc(1, 1, 0, 0, 1, expWin(w, 0), 0, 0, "R7 no skip after");
  endtask

  task automatic testStall();
    logic [59:0] w = 60'h7E7_E7E7_1818_2424;
    doFlush(w);
    cyc(1, 0, 0, 0, 1, expWin(w, 0), 0, 0, "R3 p0");
    cyc(1, 0, 1, 0, 1, expWin(w, 1), 0, 0, "R8 stall p1 a");
    cyc(1, 0, 1, 0, 1, expWin(w, 1), 0, 0, "R8 stall p1 b");
    cyc(1, 1, 0, 0, 1, expWin(w, 1), 0, 0, "R8 long p1");
    cyc(1, 0, 1, 0, 0, '0, 0, 0, "R8 stalled skip");
    cyc(1, 0, 0, 0, 0, '0, 0, 0, "R8 skip held");
    cyc(1, 0, 1, 0, 1, expWin(w, 3), 0, 0, "R8 stall at p3");
    cyc(1, 0, 0, 0, 1, expWin(w, 3), 1, 0, "R8 released p3");
  endtask

  task automatic testFlushMid();
    logic [59:0] w = 60'h246_8ACE_1357_9BDF;
    doFlush(w);
    cyc(1, 1, 0, 0, 1, expWin(w, 0), 0, 0, "R4 long p0");
    wordIn = 60'h999_8888_7777_6666;
    cyc(1, 0, 0, 1, 0, '0, 0, 0, "R9 flush in skip");
    cyc(1, 0, 0, 0, 1, expWin(wordIn, 0), 0, 0, "R9 new word p0");
  endtask

  task automatic testNoWord();
    logic [59:0] w = 60'hABC_DEF0_1234_5678;
    doFlush(w);
    cyc(1, 0, 0, 0, 1, expWin(w, 0), 0, 0, "R3 p0");
    cyc(0, 0, 0, 0, 0, '0, 0, 0, "R10 no word a");
    cyc(0, 1, 0, 0, 0, '0, 0, 0, "R10 no word b");
    cyc(1, 0, 0, 0, 1, expWin(w, 1), 0, 0, "R10 pointer held p1");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAllShort();
    testLongFirst();
    testLongThird();
    testLongLast();
    testStall();
    testFlushMid();
    testNoWord();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule